// File: doc/BRIEF.md
# Dual-Channel Current DAC Command Receiver

This block is the digital front end of a two-channel current-output DAC, seen from the device side. A host writes 16-bit command words over a three-wire serial port made of an active-low chip select, a serial clock and a data line. The block samples the serial pins into a fast system clock, detects falling serial-clock edges, assembles each word and decodes it once the word is complete.

A decoded command can switch the reference between external and internal. It can also load a 10-bit code into channel A, channel B or both. In that same write it sets the full-scale range flag of each channel it loads. The outputs are the live register contents that drive the analog array, plus a one-cycle update strobe per channel that marks each write to that channel.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset, `ref_int_o` is 0 (external reference), both range flags are 0 (low full scale), both codes are 000h and both strobes are low.
- R2: Bits are sampled on falling edges of `sclk_i` while `cs_ni` is low, most significant bit first. Word bits [15:12] are the control field, [11:2] the code (bit 11 is the code MSB) and [1:0] the trailing field. Reception works with the clock idling low or idling high.
- R3: Control 0000 clears `ref_int_o` and control 1000 sets it. For these two controls the code field is ignored, no code or range changes and no strobe fires.
- R4: Control 001r loads the code into channel A and sets `range_hi_a_o` to r. Channel B is untouched.
- R5: Control 010r loads the code into channel B and sets `range_hi_b_o` to r. Channel A is untouched.
- R6: Control 011r loads the same code into both channels and sets both range flags to r.
- R7: Any other control value changes no register and fires no strobe.
- R8: A word whose trailing field is not 00 changes no register and fires no strobe.
- R9: If `cs_ni` rises before 16 falling edges, the partial word is dropped. The next frame counts bits from zero after the next chip-select fall.
- R10: Falling edges after the 16th in the same frame are ignored until `cs_ni` goes high.
- R11: Each channel's strobe is high for exactly one cycle per write to that channel. A channel's code and range change only in the cycle its strobe is high.
- R12: No register changes before the 16th falling edge of a frame. The decoded update appears a few system clocks after that edge, with chip select still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; data sampled on its falling edge |
| din_i | input | 1 | Serial data in |
| ref_int_o | output | 1 | 1 selects the internal reference, 0 the external one |
| code_a_o | output | 10 | Channel A code |
| code_b_o | output | 10 | Channel B code |
| range_hi_a_o | output | 1 | Channel A range: 1 high full scale, 0 low |
| range_hi_b_o | output | 1 | Channel B range: 1 high full scale, 0 low |
| upd_a_o | output | 1 | One-cycle strobe on each write to channel A |
| upd_b_o | output | 1 | One-cycle strobe on each write to channel B |

## Verification
The assertions check these rules on every cycle:
- a channel's code and range move only together with its own strobe;
- each strobe lasts exactly one cycle;
- a reference change never fires a strobe;
- a dual-channel write leaves both channels equal;
- nothing is written while chip select has been high for a while.

The decode table itself needs the bench's scenarios: which opcode hits which channel, that reserved opcodes and nonzero trailing bits are rejected, that short frames are dropped and extra edges ignored, and that the update waits for the sixteenth edge. Both clock idle polarities are also covered there.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CTRL_W  = 4;
  localparam int CODE_W  = 10;
  localparam int TRAIL_W = 2;
  localparam int WORD_W  = CTRL_W + CODE_W + TRAIL_W;
  localparam int NUM_CH  = 2;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic [CTRL_W-1:0]  ctrl;
    code_t              code;
    logic [TRAIL_W-1:0] trail;
  } cmd_word_t;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dac_rx_framer.sv
module dac_rx_framer import dac_cmd_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_ni,
  input  logic      sclk_i,
  input  logic      din_i,
  output cmd_word_t word_o,
  output logic      valid_o
);
  localparam int               CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;
  logic              valid_q;
  logic              shift_en;

  // falling edge of the synchronised clock, frame open and not yet full
  assign shift_en = sclk_q & ~sclk_i & ~cs_ni & (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      sr_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      valid_q <= 1'b0;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (shift_en) begin
        sr_q    <= {sr_q[WORD_W-2:0], din_i};
        cnt_q   <= cnt_q + 1'b1;
        valid_q <= (cnt_q == LAST);
      end
    end
  end

  assign word_o  = cmd_word_t'(sr_q);
  assign valid_o = valid_q;
endmodule

// File: rtl/dac_rx_regs.sv
module dac_rx_regs import dac_cmd_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  cmd_word_t word_i,
  output logic      ref_int_o,
  output code_t     code_o  [NUM_CH],
  output logic      range_o [NUM_CH],
  output logic      upd_o   [NUM_CH]
);
  logic accept;
  logic ref_hit;
  logic ref_q;

  assign accept  = valid_i && (word_i.trail == '0);
  // ctrl = x000 : reference select, bit 3 picks internal
  assign ref_hit = accept && (word_i.ctrl[CTRL_W-2:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ref_q <= 1'b0;
    else if (ref_hit) ref_q <= word_i.ctrl[CTRL_W-1];
  end
  assign ref_int_o = ref_q;

  // ctrl = 0 sel[1:0] r : sel bit per channel, r = range
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic  hit;
    code_t code_q;
    logic  range_q;
    logic  upd_q;

    assign hit = accept && !word_i.ctrl[CTRL_W-1] && word_i.ctrl[ch+1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q  <= '0;
        range_q <= 1'b0;
        upd_q   <= 1'b0;
      end else begin
        upd_q <= hit;
        if (hit) begin
          code_q  <= word_i.code;
          range_q <= word_i.ctrl[0];
        end
      end
    end

    assign code_o[ch]  = code_q;
    assign range_o[ch] = range_q;
    assign upd_o[ch]   = upd_q;
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx import dac_cmd_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              ref_int_o,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              range_hi_a_o,
  output logic              range_hi_b_o,
  output logic              upd_a_o,
  output logic              upd_b_o
);
  logic [2:0] pins_s;
  cmd_word_t  word;
  logic       word_vld;
  code_t      code   [NUM_CH];
  logic       range_f[NUM_CH];
  logic       upd    [NUM_CH];

  dac_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  dac_rx_framer u_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (pins_s[2]),
    .sclk_i (pins_s[1]),
    .din_i  (pins_s[0]),
    .word_o (word),
    .valid_o(word_vld)
  );

  dac_rx_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (word_vld),
    .word_i   (word),
    .ref_int_o(ref_int_o),
    .code_o   (code),
    .range_o  (range_f),
    .upd_o    (upd)
  );

  assign code_a_o     = code[0];
  assign code_b_o     = code[1];
  assign range_hi_a_o = range_f[0];
  assign range_hi_b_o = range_f[1];
  assign upd_a_o      = upd[0];
  assign upd_b_o      = upd[1];
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk import dac_cmd_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              ref_int_o,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              range_hi_a_o,
  input logic              range_hi_b_o,
  input logic              upd_a_o,
  input logic              upd_b_o
);
  localparam int IDLE_LIM = SYNC_STAGES + 6;
  int cs_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cs_hi_cnt <= 0;
    else if (!cs_ni)               cs_hi_cnt <= 0;
    else if (cs_hi_cnt < IDLE_LIM) cs_hi_cnt <= cs_hi_cnt + 1;
  end

  AST_A_CHG_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({range_hi_a_o, code_a_o}) |-> upd_a_o); // R11
  AST_B_CHG_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({range_hi_b_o, code_b_o}) |-> upd_b_o); // R11
  AST_A_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_a_o |=> !upd_a_o); // R11
  AST_B_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_b_o |=> !upd_b_o); // R11
  AST_REF_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_int_o) |-> !upd_a_o && !upd_b_o); // R3
  AST_DUAL_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_a_o && upd_b_o |-> code_a_o == code_b_o && range_hi_a_o == range_hi_b_o); // R6
  AST_NO_UPD_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_cnt >= IDLE_LIM |-> !upd_a_o && !upd_b_o); // R9
endmodule

bind dac_cmd_rx dac_cmd_rx_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/dac_cmd_rx_tb_top.sv
module dac_cmd_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic ref_int, rng_a, rng_b, upd_a, upd_b;
  logic [9:0] code_a, code_b;

  always #2 clk = ~clk;

  dac_cmd_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .ref_int_o(ref_int), .code_a_o(code_a), .code_b_o(code_b),
    .range_hi_a_o(rng_a), .range_hi_b_o(rng_b), .upd_a_o(upd_a), .upd_b_o(upd_b)
  );

  int checks = 0;
  int errors = 0;
  int cnt_a = 0, cnt_b = 0;
  logic prev_a = 1'b0, prev_b = 1'b0, wide = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_a = 1'b0; prev_b = 1'b0;
    end else begin
      if (upd_a) cnt_a++;
      if (upd_b) cnt_b++;
      if ((upd_a && prev_a) || (upd_b && prev_b)) wide = 1'b1;
      prev_a = upd_a; prev_b = upd_b;
    end
  end

  // state = {ref, code_a, range_a, code_b, range_b}
  typedef struct packed {
    logic [15:0] w;
    logic        cpol;
    logic [22:0] st;
    logic [1:0]  pa;
    logic [1:0]  pb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{{4'b0010, 10'h155, 2'b00}, 1'b0, {1'b0, 10'h155, 1'b0, 10'h000, 1'b0}, 2'd1, 2'd0, 4'd4},  // R4
    '{{4'b0101, 10'h3FF, 2'b00}, 1'b1, {1'b0, 10'h155, 1'b0, 10'h3FF, 1'b1}, 2'd0, 2'd1, 4'd5},  // R5
    '{{4'b1000, 10'h2AA, 2'b00}, 1'b0, {1'b1, 10'h155, 1'b0, 10'h3FF, 1'b1}, 2'd0, 2'd0, 4'd3},  // R3
    '{{4'b0011, 10'h001, 2'b00}, 1'b1, {1'b1, 10'h001, 1'b1, 10'h3FF, 1'b1}, 2'd1, 2'd0, 4'd4},  // R4
    '{{4'b0111, 10'h200, 2'b00}, 1'b0, {1'b1, 10'h200, 1'b1, 10'h200, 1'b1}, 2'd1, 2'd1, 4'd6},  // R6
    '{{4'b0110, 10'h0F0, 2'b00}, 1'b1, {1'b1, 10'h0F0, 1'b0, 10'h0F0, 1'b0}, 2'd1, 2'd1, 4'd6},  // R6
    '{{4'b1100, 10'h3FF, 2'b00}, 1'b0, {1'b1, 10'h0F0, 1'b0, 10'h0F0, 1'b0}, 2'd0, 2'd0, 4'd7},  // R7
    '{{4'b0001, 10'h123, 2'b00}, 1'b1, {1'b1, 10'h0F0, 1'b0, 10'h0F0, 1'b0}, 2'd0, 2'd0, 4'd7},  // R7
    '{{4'b0010, 10'h3C3, 2'b01}, 1'b0, {1'b1, 10'h0F0, 1'b0, 10'h0F0, 1'b0}, 2'd0, 2'd0, 4'd8},  // R8
    '{{4'b0000, 10'h3FF, 2'b00}, 1'b1, {1'b0, 10'h0F0, 1'b0, 10'h0F0, 1'b0}, 2'd0, 2'd0, 4'd3},  // R3
    '{{4'b0100, 10'h05A, 2'b00}, 1'b0, {1'b0, 10'h0F0, 1'b0, 10'h05A, 1'b0}, 2'd0, 2'd1, 4'd5}   // R5, R2
  };

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin(logic cpol);
    sclk = cpol; wait_clk(4);
    cs_n = 1'b0; wait_clk(6);
  endtask

  task automatic shift_bits(logic [31:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i]; wait_clk(5);
      sclk = 1'b1;   wait_clk(5);
      sclk = 1'b0;   wait_clk(5);
    end
  endtask

  task automatic frame_end(logic cpol);
    wait_clk(6); sclk = cpol; wait_clk(3);
    cs_n = 1'b1; wait_clk(10);
  endtask

  task automatic check(string req, logic [22:0] exp_st, int exp_pa, int exp_pb, int pa0, int pb0);
    logic [22:0] act;
    act = {ref_int, code_a, rng_a, code_b, rng_b};
    checks++;
    if (act !== exp_st || cnt_a - pa0 != exp_pa || cnt_b - pb0 != exp_pb) begin
      errors++;
      $display("FAIL %s state act=%h exp=%h strobes act=%0d/%0d exp=%0d/%0d",
               req, act, exp_st, cnt_a - pa0, cnt_b - pb0, exp_pa, exp_pb);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pa0, pb0;
    wait_clk(3);
    checks++;  // R1 during reset
    if ({ref_int, code_a, rng_a, code_b, rng_b, upd_a, upd_b} !== 25'd0) begin
      errors++; $display("FAIL R1 in reset act=%h exp=0", {ref_int, code_a, rng_a, code_b, rng_b});
    end
    rst_n = 1'b1; wait_clk(10);
    check("R1", 23'd0, 0, 0, 0, 0);

    for (int v = 0; v < NV; v++) begin
      pa0 = cnt_a; pb0 = cnt_b;
      frame_begin(VECS[v].cpol);
      shift_bits({16'h0, VECS[v].w}, 16);
      frame_end(VECS[v].cpol);
      check($sformatf("R%0d/R2 vec%0d", VECS[v].req, v), VECS[v].st, VECS[v].pa, VECS[v].pb, pa0, pb0);
    end

    // R9: short frame dropped
    pa0 = cnt_a; pb0 = cnt_b;
    frame_begin(1'b0);
    shift_bits({16'h0, 4'b0010, 10'h3FF, 2'b00} >> 6, 10);
    frame_end(1'b0);
    check("R9 short", {1'b0, 10'h0F0, 1'b0, 10'h05A, 1'b0}, 0, 0, pa0, pb0);
    // R9: next frame starts from bit zero
    pa0 = cnt_a; pb0 = cnt_b;
    frame_begin(1'b0);
    shift_bits({16'h0, 4'b0011, 10'h111, 2'b00}, 16);
    frame_end(1'b0);
    check("R9 restart", {1'b0, 10'h111, 1'b1, 10'h05A, 1'b0}, 1, 0, pa0, pb0);

    // R10: extra edges after the word
    pa0 = cnt_a; pb0 = cnt_b;
    frame_begin(1'b1);
    shift_bits({16'h0, 4'b0101, 10'h0AB, 2'b00}, 16);
    shift_bits(32'hF, 4);
    frame_end(1'b1);
    check("R10 extra", {1'b0, 10'h111, 1'b1, 10'h0AB, 1'b1}, 0, 1, pa0, pb0);

    // R12: nothing before the 16th edge, update right after it
    pa0 = cnt_a; pb0 = cnt_b;
    frame_begin(1'b1);
    shift_bits({16'h0, 4'b0110, 10'h03C, 2'b00} >> 1, 15);
    wait_clk(20);
    check("R12 15 edges", {1'b0, 10'h111, 1'b1, 10'h0AB, 1'b1}, 0, 0, pa0, pb0);
    shift_bits(32'h0, 1);
    wait_clk(10);
    check("R12 16th edge", {1'b0, 10'h03C, 1'b0, 10'h03C, 1'b0}, 1, 1, pa0, pb0);
    frame_end(1'b1);

    checks++;  // R11 strobe width
    if (wide) begin
      errors++; $display("FAIL R11 strobe width act=>1 exp=1");
    end

    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(5);
    check("R1 re-reset", 23'd0, 0, 0, cnt_a, cnt_b);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule